// File: doc/BRIEF.md
# Serial In-System Programming Slave

This block lets an external programmer load, wipe and inspect two small on-chip memories over a three-wire serial link. One memory holds program words, each made of a low and a high byte. The other holds single data bytes and behaves like EEPROM. The programmer drives the serial clock and the serial data in, and reads the serial data out. The link is live only while the active-low entry input `prog_n` is held low. While `prog_n` is high, the clock and data pins are ignored and the output is quiet.

The system clock oversamples `prog_n`, the serial clock and the data input through a two-stage synchronizer. Data is taken in on each detected rising edge of the serial clock, most significant bit first. Every instruction is a frame of four bytes. The first two bytes are the opcode. The third byte is the address. The fourth byte carries the write data, or returns the read value on the output.

A frame of 0xAC 0x53 turns programming on. Until such a frame has been accepted, every other instruction is dropped. Writes and chip erase start a self-timed busy window, which the programmer can poll. A phase of the serial clock that is too short, measured in system clocks, raises an error flag.

Top module: `isp_serial_prog`

## Requirements
- R1: While `prog_n` is high, `miso_oe` and `miso` stay low, `miso_oe` follows the inverse of `prog_n` two clocks late, and a frame clocked in has no effect on either memory.
- R2: After each entry, every instruction other than 0xAC 0x53 x x is discarded until 0xAC 0x53 x x has been received. Before that point, byte 4 of a read or a poll returns 0x00.
- R3: In any frame whose first two bytes are 0xAC 0x53, `miso` returns 0x53 during byte 3, which is how the programmer confirms alignment.
- R4: A frame is four bytes, each sent MSB first, and data is taken in on SCK rising edges. The address is byte 3, taken modulo the memory depth. Byte 4 is the write data, and byte 4 of a read returns the selected location.
- R5: Chip erase (0xAC 0x80 x x) sets every location in both memories to 0xFF.
- R6: A data write (0xC0 x addr data) replaces the whole stored byte, with the erase built in. A data read is 0xA0 x addr x.
- R7: A program write of the low byte (0x40) or the high byte (0x48) can only clear bits, so the stored value becomes old AND data. A read of the low byte is 0x20 and a read of the high byte is 0x28.
- R8: Each accepted write or erase makes the block busy for WR_CYCLES system clocks. While busy, a poll (0xF0 x x x) returns 0x01 in byte 4, and any further write or erase is ignored. Once the window is over, a poll returns 0x00.
- R9: An SCK high or low phase that lasts LIMIT system clocks or fewer sets `sck_err`. LIMIT is 2 when FAST_CLK is 0 and 3 otherwise. The flag stays set while the link is active and clears when `prog_n` goes high.
- R10: Raising `prog_n` in the middle of a frame clears the byte position and the enable state, so a new enable frame is needed after re-entry.
- R11: A synchronous `rst` fills both memories with 0xFF, clears the enable state and drives `miso_oe` and `sck_err` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_n | input | 1 | Active-low programming entry |
| sck | input | 1 | Serial clock from the programmer |
| mosi | input | 1 | Serial data into the block |
| miso | output | 1 | Serial data out of the block |
| miso_oe | output | 1 | Output enable for `miso` |
| sck_err | output | 1 | Sticky flag for an SCK phase that was too short |

## Verification
The bench builds the block with FAST_CLK = 0, so a two-clock SCK phase must raise the flag and a three-clock phase must not. Both sides of that limit can therefore be driven directly. WR_CYCLES = 1000 is longer than two frames at a six-clock half period. As a result, a rejected erase and a poll that reads 1 both fit inside one busy window. Memories of 16 entries keep the erase sweep short and make address wrap reachable with a one-byte address.

// File: rtl/isp_pkg.sv
package isp_pkg;

    localparam int FRAME_BYTES = 4;
    localparam int IDX_W       = $clog2(FRAME_BYTES);

    localparam logic [7:0] OP_ENTRY    = 8'hAC;
    localparam logic [7:0] SUB_ENABLE  = 8'h53;
    localparam logic [7:0] SUB_ERASE   = 8'h80;
    localparam logic [7:0] OP_PM_WR_LO = 8'h40;
    localparam logic [7:0] OP_PM_WR_HI = 8'h48;
    localparam logic [7:0] OP_PM_RD_LO = 8'h20;
    localparam logic [7:0] OP_PM_RD_HI = 8'h28;
    localparam logic [7:0] OP_DM_WR    = 8'hC0;
    localparam logic [7:0] OP_DM_RD    = 8'hA0;
    localparam logic [7:0] OP_POLL     = 8'hF0;

    typedef enum logic [3:0] {
        CMD_NONE,
        CMD_ENABLE,
        CMD_ERASE,
        CMD_PM_WR_LO,
        CMD_PM_WR_HI,
        CMD_PM_RD_LO,
        CMD_PM_RD_HI,
        CMD_DM_WR,
        CMD_DM_RD,
        CMD_POLL
    } cmd_e;

    typedef struct packed {
        logic [7:0] op;
        logic [7:0] sub;
        logic [7:0] addr;
        logic [7:0] data;
    } frame_t;

    function automatic cmd_e decode(input logic [7:0] op, input logic [7:0] sub);
        cmd_e c;
        case (op)
            OP_ENTRY: begin
                if (sub == SUB_ENABLE)     c = CMD_ENABLE;
                else if (sub == SUB_ERASE) c = CMD_ERASE;
                else                       c = CMD_NONE;
            end
            OP_PM_WR_LO: c = CMD_PM_WR_LO;
            OP_PM_WR_HI: c = CMD_PM_WR_HI;
            OP_PM_RD_LO: c = CMD_PM_RD_LO;
            OP_PM_RD_HI: c = CMD_PM_RD_HI;
            OP_DM_WR:    c = CMD_DM_WR;
            OP_DM_RD:    c = CMD_DM_RD;
            OP_POLL:     c = CMD_POLL;
            default:     c = CMD_NONE;
        endcase
        return c;
    endfunction

    function automatic logic is_write(input cmd_e c);
        return (c == CMD_ERASE) || (c == CMD_PM_WR_LO) ||
               (c == CMD_PM_WR_HI) || (c == CMD_DM_WR);
    endfunction

    // Longest SCK phase, in system clocks, that still counts as too short.
    function automatic int phase_limit(input bit fast_clk);
        return fast_clk ? 3 : 2;
    endfunction

endpackage

// File: rtl/isp_sync_edge.sv
module isp_sync_edge
    import isp_pkg::*;
#(
    parameter bit FAST_CLK    = 1'b0,
    parameter int SYNC_STAGES = 2,
    parameter int PH_W        = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic prog_n,
    input  logic sck,
    input  logic mosi,
    output logic active,
    output logic sck_rise,
    output logic sck_fall,
    output logic mosi_s,
    output logic sck_err
);
    localparam logic [PH_W-1:0] LIM_V  = PH_W'(phase_limit(FAST_CLK));
    localparam logic [PH_W-1:0] PH_MAX = '1;

    // Bit 2: prog_n, bit 1: sck, bit 0: mosi, all delayed together.
    logic [2:0] stg [SYNC_STAGES];
    logic       sck_s, sck_d, sck_edge;
    logic [PH_W-1:0] ph_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SYNC_STAGES; i++) stg[i] <= 3'b100;
        end else begin
            stg[0] <= {prog_n, sck, mosi};
            for (int i = 1; i < SYNC_STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign active   = ~stg[SYNC_STAGES-1][2];
    assign sck_s    = stg[SYNC_STAGES-1][1];
    assign mosi_s   = stg[SYNC_STAGES-1][0];
    assign sck_edge = active && (sck_s != sck_d);
    assign sck_rise = sck_edge && sck_s;
    assign sck_fall = sck_edge && !sck_s;

    always_ff @(posedge clk) begin
        if (rst) sck_d <= 1'b0;
        else     sck_d <= sck_s;
    end

    // Phase length monitor: ph_cnt holds the clocks seen since the last edge.
    always_ff @(posedge clk) begin
        if (rst || !active) begin
            ph_cnt  <= PH_MAX;
            sck_err <= 1'b0;
        end else if (sck_edge) begin
            ph_cnt <= PH_W'(1);
            if (ph_cnt <= LIM_V) sck_err <= 1'b1;
        end else if (ph_cnt != PH_MAX) begin
            ph_cnt <= ph_cnt + PH_W'(1);
        end
    end
endmodule

// File: rtl/isp_shifter.sv
module isp_shifter
    import isp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic             sck_rise,
    input  logic             sck_fall,
    input  logic             mosi_s,
    input  logic [7:0]       tx_next,
    output logic [7:0]       rx_now,
    output logic [IDX_W-1:0] byte_idx,
    output logic             byte_end,
    output frame_t           frm,
    output logic             frame_done,
    output logic             miso_bit
);
    logic [2:0] bit_cnt;
    logic [6:0] rx;
    logic [7:0] tx;
    logic [7:0] bytes [FRAME_BYTES];

    assign rx_now   = {rx, mosi_s};
    assign byte_end = sck_rise && (bit_cnt == 3'd7);
    assign miso_bit = tx[7];
    assign frm      = {bytes[0], bytes[1], bytes[2], bytes[3]};

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            bit_cnt    <= '0;
            rx         <= '0;
            tx         <= '0;
            byte_idx   <= '0;
            frame_done <= 1'b0;
            for (int i = 0; i < FRAME_BYTES; i++) bytes[i] <= '0;
        end else begin
            frame_done <= byte_end && (byte_idx == IDX_W'(FRAME_BYTES - 1));
            if (sck_rise) begin
                rx      <= rx_now[6:0];
                bit_cnt <= bit_cnt + 3'd1;
            end
            if (byte_end) begin
                bytes[byte_idx] <= rx_now;
                byte_idx        <= byte_idx + IDX_W'(1);
                tx              <= tx_next;
            end else if (sck_fall && bit_cnt != 3'd0) begin
                tx <= {tx[6:0], 1'b0};
            end
        end
    end
endmodule

// File: rtl/isp_mem.sv
module isp_mem
    import isp_pkg::*;
#(
    parameter int PM_WORDS  = 16,
    parameter int DM_BYTES  = 16,
    parameter int WR_CYCLES = 1000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_go,
    input  cmd_e       wr_cmd,
    input  logic [7:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic [7:0] rd_addr,
    output logic [7:0] pm_lo_q,
    output logic [7:0] pm_hi_q,
    output logic [7:0] dm_q,
    output logic       busy
);
    localparam int PM_AW = (PM_WORDS > 1) ? $clog2(PM_WORDS) : 1;
    localparam int DM_AW = (DM_BYTES > 1) ? $clog2(DM_BYTES) : 1;
    localparam int TW    = $clog2(WR_CYCLES + 1);

    logic [7:0] pm_lo [PM_WORDS];
    logic [7:0] pm_hi [PM_WORDS];
    logic [7:0] dm    [DM_BYTES];
    logic [TW-1:0] cnt;
    logic [PM_AW-1:0] pw, pr;
    logic [DM_AW-1:0] dw, dr;

    assign pw = PM_AW'(wr_addr % PM_WORDS);
    assign pr = PM_AW'(rd_addr % PM_WORDS);
    assign dw = DM_AW'(wr_addr % DM_BYTES);
    assign dr = DM_AW'(rd_addr % DM_BYTES);

    assign pm_lo_q = pm_lo[pr];
    assign pm_hi_q = pm_hi[pr];
    assign dm_q    = dm[dr];
    assign busy    = (cnt != '0);

    always_ff @(posedge clk) begin
        if (rst)        cnt <= '0;
        else if (wr_go) cnt <= TW'(WR_CYCLES);
        else if (busy)  cnt <= cnt - TW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst || (wr_go && wr_cmd == CMD_ERASE)) begin
            for (int i = 0; i < PM_WORDS; i++) begin
                pm_lo[i] <= 8'hFF;
                pm_hi[i] <= 8'hFF;
            end
            for (int j = 0; j < DM_BYTES; j++) dm[j] <= 8'hFF;
        end else if (wr_go) begin
            case (wr_cmd)
                CMD_PM_WR_LO: pm_lo[pw] <= pm_lo[pw] & wr_data;
                CMD_PM_WR_HI: pm_hi[pw] <= pm_hi[pw] & wr_data;
                CMD_DM_WR:    dm[dw]    <= wr_data;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/isp_serial_prog.sv
module isp_serial_prog
    import isp_pkg::*;
#(
    parameter bit FAST_CLK  = 1'b0,
    parameter int PM_WORDS  = 16,
    parameter int DM_BYTES  = 16,
    parameter int WR_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic prog_n,
    input  logic sck,
    input  logic mosi,
    output logic miso,
    output logic miso_oe,
    output logic sck_err
);
    logic             active, sck_rise, sck_fall, mosi_s;
    logic [7:0]       rx_now, tx_next;
    logic [IDX_W-1:0] byte_idx;
    logic             byte_end, frame_done, miso_bit;
    frame_t           frm;
    cmd_e             cmd_now;
    logic             en, wr_go, busy;
    logic [7:0]       pm_lo_q, pm_hi_q, dm_q;

    isp_sync_edge #(.FAST_CLK(FAST_CLK)) u_sync (
        .clk(clk), .rst(rst), .prog_n(prog_n), .sck(sck), .mosi(mosi),
        .active(active), .sck_rise(sck_rise), .sck_fall(sck_fall),
        .mosi_s(mosi_s), .sck_err(sck_err)
    );

    isp_shifter u_shift (
        .clk(clk), .rst(rst), .active(active), .sck_rise(sck_rise),
        .sck_fall(sck_fall), .mosi_s(mosi_s), .tx_next(tx_next),
        .rx_now(rx_now), .byte_idx(byte_idx), .byte_end(byte_end),
        .frm(frm), .frame_done(frame_done), .miso_bit(miso_bit)
    );

    isp_mem #(.PM_WORDS(PM_WORDS), .DM_BYTES(DM_BYTES), .WR_CYCLES(WR_CYCLES)) u_mem (
        .clk(clk), .rst(rst), .wr_go(wr_go), .wr_cmd(cmd_now),
        .wr_addr(frm.addr), .wr_data(frm.data), .rd_addr(rx_now),
        .pm_lo_q(pm_lo_q), .pm_hi_q(pm_hi_q), .dm_q(dm_q), .busy(busy)
    );

    assign cmd_now = decode(frm.op, frm.sub);
    assign wr_go   = frame_done && en && !busy && is_write(cmd_now);

    always_ff @(posedge clk) begin
        if (rst || !active)                          en <= 1'b0;
        else if (frame_done && cmd_now == CMD_ENABLE) en <= 1'b1;
    end

    // Byte loaded for the next slot when the current byte completes.
    always_comb begin
        tx_next = 8'h00;
        if (byte_idx == IDX_W'(1)) begin
            if (frm.op == OP_ENTRY && rx_now == SUB_ENABLE) tx_next = SUB_ENABLE;
        end else if (byte_idx == IDX_W'(2) && en) begin
            case (cmd_now)
                CMD_PM_RD_LO: tx_next = pm_lo_q;
                CMD_PM_RD_HI: tx_next = pm_hi_q;
                CMD_DM_RD:    tx_next = dm_q;
                CMD_POLL:     tx_next = {7'b0, busy};
                default:      tx_next = 8'h00;
            endcase
        end
    end

    assign miso_oe = active;
    assign miso    = active & miso_bit;
endmodule

// File: rtl/isp_checker.sv
module isp_checker
    import isp_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             prog_n,
    input logic             miso,
    input logic             miso_oe,
    input logic             sck_err,
    input logic             active,
    input logic             en,
    input logic             wr_go,
    input logic             busy,
    input logic             frame_done,
    input logic             byte_end,
    input logic [IDX_W-1:0] byte_idx
);
    p_quiet_off_r1: assert property (@(posedge clk) disable iff (rst)
        (prog_n && $past(prog_n) && $past(prog_n, 2)) |-> (!miso_oe && !miso));

    p_write_needs_enable_r2: assert property (@(posedge clk) disable iff (rst)
        wr_go |-> en);

    p_frame_four_bytes_r4: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> ($past(byte_end) && byte_idx == '0));

    p_busy_blocks_r8: assert property (@(posedge clk) disable iff (rst)
        busy |-> !wr_go);

    p_go_sets_busy_r8: assert property (@(posedge clk) disable iff (rst)
        wr_go |=> busy);

    p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (sck_err && active) |=> (sck_err || !active));

    p_exit_clears_r10: assert property (@(posedge clk) disable iff (rst)
        !active |=> (!en && byte_idx == '0));
endmodule

bind isp_serial_prog isp_checker u_chk (
    .clk(clk), .rst(rst), .prog_n(prog_n), .miso(miso), .miso_oe(miso_oe),
    .sck_err(sck_err), .active(active), .en(en), .wr_go(wr_go), .busy(busy),
    .frame_done(frame_done), .byte_end(byte_end), .byte_idx(byte_idx)
);

// File: tb/tb_isp_serial_prog.sv
`timescale 1ns/1ps
module tb_isp_serial_prog;
    localparam int WR   = 1000;
    localparam int HALF = 6;
    localparam int PMW  = 16;
    localparam int DMB  = 16;

    logic clk = 1'b0, rst = 1'b1, prog_n = 1'b1, sck = 1'b0, mosi = 1'b0;
    logic miso, miso_oe, sck_err;

    always #2.5 clk = ~clk;

    isp_serial_prog #(.FAST_CLK(1'b0), .PM_WORDS(PMW), .DM_BYTES(DMB), .WR_CYCLES(WR)) dut (
        .clk(clk), .rst(rst), .prog_n(prog_n), .sck(sck), .mosi(mosi),
        .miso(miso), .miso_oe(miso_oe), .sck_err(sck_err)
    );

    int n_chk = 0, n_bad = 0;
    longint cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // Behavioural reference state
    logic [7:0] m_pl [PMW];
    logic [7:0] m_ph [PMW];
    logic [7:0] m_dm [DMB];
    bit         m_en = 1'b0;
    longint     m_wstart = -100000;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // R1: output enable tracks the entry pin two clocks late, checked every clock
    logic [1:0] hist = 2'b11;
    always @(posedge clk) hist <= {hist[0], prog_n};
    always @(negedge clk)
        if (!rst) chk(miso_oe == !hist[1], "R1", "miso_oe", int'(miso_oe), int'(!hist[1]));

    function automatic bit m_busy();
        return (cyc - m_wstart) < WR;
    endfunction

    function automatic logic [7:0] m_read(input logic [7:0] b0, input logic [7:0] b2);
        if (!m_en) return 8'h00;
        case (b0)
            8'h20:   return m_pl[b2 % PMW];
            8'h28:   return m_ph[b2 % PMW];
            8'hA0:   return m_dm[b2 % DMB];
            8'hF0:   return {7'b0, m_busy()};
            default: return 8'h00;
        endcase
    endfunction

    task automatic m_exec(input logic [7:0] b0, b1, b2, b3);
        if (b0 == 8'hAC && b1 == 8'h53) begin
            m_en = 1'b1;
        end else if (m_en && !m_busy()) begin
            if (b0 == 8'hAC && b1 == 8'h80) begin
                for (int i = 0; i < PMW; i++) begin m_pl[i] = 8'hFF; m_ph[i] = 8'hFF; end
                for (int i = 0; i < DMB; i++) m_dm[i] = 8'hFF;
                m_wstart = cyc;
            end else if (b0 == 8'h40) begin
                m_pl[b2 % PMW] = m_pl[b2 % PMW] & b3; m_wstart = cyc;
            end else if (b0 == 8'h48) begin
                m_ph[b2 % PMW] = m_ph[b2 % PMW] & b3; m_wstart = cyc;
            end else if (b0 == 8'hC0) begin
                m_dm[b2 % DMB] = b3; m_wstart = cyc;
            end
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic [7:0] r);
        for (int i = 7; i >= 0; i--) begin
            @(negedge clk);
            mosi = b[i];
            repeat (HALF - 1) @(negedge clk);
            r[i] = miso;
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
            sck = 1'b0;
        end
    endtask

    task automatic frame(input logic [7:0] b0, b1, b2, b3, input string req);
        logic [7:0] r;
        logic [7:0] e3;
        bit act;
        act = !prog_n;
        send_byte(b0, r);
        send_byte(b1, r);
        send_byte(b2, r);
        chk(r == ((act && b0 == 8'hAC && b1 == 8'h53) ? 8'h53 : 8'h00),
            (b0 == 8'hAC && b1 == 8'h53) ? "R3" : req, "byte3 resp", r,
            (act && b0 == 8'hAC && b1 == 8'h53) ? 8'h53 : 8'h00);
        e3 = act ? m_read(b0, b2) : 8'h00;
        send_byte(b3, r);
        chk(r == e3, req, "byte4 resp", r, e3);
        repeat (6) @(negedge clk);
        if (act) m_exec(b0, b1, b2, b3);
    endtask

    task automatic wait_wr();
        repeat (WR + 50) @(negedge clk);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] r;
        for (int i = 0; i < PMW; i++) begin m_pl[i] = 8'hFF; m_ph[i] = 8'hFF; end
        for (int i = 0; i < DMB; i++) m_dm[i] = 8'hFF;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk(miso_oe == 1'b0, "R11", "miso_oe after reset", miso_oe, 0);
        chk(sck_err == 1'b0, "R11", "sck_err after reset", sck_err, 0);
        chk(miso == 1'b0, "R1", "miso idle", miso, 0);

        // R1: frame while inactive, dm write attempt
        frame(8'hC0, 8'h00, 8'h02, 8'h55, "R1");
        prog_n = 1'b0; repeat (6) @(negedge clk);

        // R2: discarded before enable
        frame(8'hC0, 8'h00, 8'h02, 8'h55, "R2");
        frame(8'hA0, 8'h00, 8'h02, 8'h00, "R2");
        frame(8'hF0, 8'h00, 8'h00, 8'h00, "R2");
        frame(8'h40, 8'h00, 8'h05, 8'h00, "R2");
        // R3: enable echo
        frame(8'hAC, 8'h53, 8'h00, 8'h00, "R3");
        // R11 / R1 / R2: memories still at 0xFF
        frame(8'hA0, 8'h00, 8'h02, 8'h00, "R11");
        frame(8'h20, 8'h00, 8'h05, 8'h00, "R11");

        // R6: data write with built-in erase
        frame(8'hC0, 8'h00, 8'h02, 8'h3C, "R6"); wait_wr();
        frame(8'hA0, 8'h00, 8'h02, 8'h00, "R6");
        frame(8'hC0, 8'h00, 8'h02, 8'hC3, "R6"); wait_wr();
        frame(8'hA0, 8'h00, 8'h02, 8'h00, "R6");

        // R7: program writes clear bits only
        frame(8'h40, 8'h00, 8'h05, 8'hF0, "R7"); wait_wr();
        frame(8'h48, 8'h00, 8'h05, 8'h5A, "R7"); wait_wr();
        frame(8'h20, 8'h00, 8'h05, 8'h00, "R7");
        frame(8'h28, 8'h00, 8'h05, 8'h00, "R7");
        frame(8'h40, 8'h00, 8'h05, 8'h3C, "R7"); wait_wr();
        frame(8'h20, 8'h00, 8'h05, 8'h00, "R7");

        // R4: address selection and wrap modulo depth
        frame(8'hC0, 8'h00, 8'h0F, 8'h81, "R4"); wait_wr();
        frame(8'hA0, 8'h00, 8'h0F, 8'h00, "R4");
        frame(8'hA0, 8'h00, 8'h0E, 8'h00, "R4");
        frame(8'hA0, 8'h00, 8'h1F, 8'h00, "R4");

        // R8: busy window
        frame(8'hC0, 8'h00, 8'h07, 8'h11, "R8");
        frame(8'hAC, 8'h80, 8'h00, 8'h00, "R8");
        frame(8'hF0, 8'h00, 8'h00, 8'h00, "R8");
        wait_wr();
        frame(8'hF0, 8'h00, 8'h00, 8'h00, "R8");
        frame(8'hA0, 8'h00, 8'h07, 8'h00, "R8");
        frame(8'h20, 8'h00, 8'h05, 8'h00, "R8");

        // R5: chip erase
        frame(8'hAC, 8'h80, 8'h00, 8'h00, "R5"); wait_wr();
        frame(8'h20, 8'h00, 8'h05, 8'h00, "R5");
        frame(8'h28, 8'h00, 8'h05, 8'h00, "R5");
        frame(8'hA0, 8'h00, 8'h02, 8'h00, "R5");
        frame(8'hA0, 8'h00, 8'h07, 8'h00, "R5");

        // R10: exit mid-frame
        send_byte(8'hA0, r);
        send_byte(8'h00, r);
        prog_n = 1'b1; m_en = 1'b0;
        repeat (6) @(negedge clk);
        prog_n = 1'b0;
        repeat (6) @(negedge clk);
        frame(8'hA0, 8'h00, 8'h0F, 8'h00, "R10");
        frame(8'hAC, 8'h53, 8'h00, 8'h00, "R10");
        frame(8'hA0, 8'h00, 8'h0F, 8'h00, "R10");

        // R9: phase limit at FAST_CLK = 0 is 2 clocks
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); sck = 1'b1;
            repeat (3) @(negedge clk); sck = 1'b0;
            repeat (2) @(negedge clk);
        end
        repeat (4) @(negedge clk);
        chk(sck_err == 1'b0, "R9", "3-clock phases", sck_err, 0);
        sck = 1'b1;
        repeat (2) @(negedge clk); sck = 1'b0;
        repeat (6) @(negedge clk);
        chk(sck_err == 1'b1, "R9", "2-clock high phase", sck_err, 1);
        sck = 1'b1; repeat (6) @(negedge clk); sck = 1'b0; repeat (6) @(negedge clk);
        chk(sck_err == 1'b1, "R9", "flag sticky", sck_err, 1);
        prog_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(sck_err == 1'b0, "R9", "flag cleared on exit", sck_err, 0);
        chk(miso == 1'b0, "R1", "miso after exit", miso, 0);

        summary();
        $finish;
    end
endmodule